// File: doc/BRIEF.md
# Alternate Operand Latch for an 8-bit Accumulator ALU

This block is the operand path of a small accumulator machine. It holds the working register W, a carry and a zero flag, and drives a register-file port. It also holds an extra 8-bit operand latch that a prefix instruction fills, either from an immediate byte or from an addressed register. For exactly one instruction after the prefix, that latch stands in for W as the ALU source operand. The substitution then lapses.

With this, a register can be copied, added to or subtracted from another register or a constant in two instruction words and two cycles, and W is never touched. Between the prefix and the instruction that consumes it, the block raises an interrupt hold output. A handler therefore never runs while the latch is live, and never has to save it.

One instruction is accepted on each cycle in which `instValid` is high. The register file is external. Its read data must be valid in the same cycle as `rfAddr`, and it writes `rfWrData` at the clock edge when `rfWrEn` is high.

Top module: `altop_unit`

## Requirements
- R1: While `rstN` is low and after its release, W, the operand latch, carry, zero and `irqHold` are all 0.
- R2: Opcode 6 (prefix-immediate) loads the latch with `immData`. The next valid instruction uses the latch as its source operand instead of W.
- R3: Opcode 7 (prefix-register) loads the latch with the contents of register `regAddr`, which is read through the register-file port.
- R4: The substitution applies only to the one valid instruction after a prefix, and that includes opcode 0 (no-op). The instruction after that uses W again.
- R5: A prefix and the move, add or subtract that consumes it leave W unchanged.
- R6: `irqHold` is 1 from the cycle after a prefix until the consuming instruction has completed. Cycles with `instValid` low do not consume the prefix.
- R7: A prefix that follows another prefix reloads the latch, and `irqHold` stays 1.
- R8: Opcode 2 (add) writes register + source to the register. Carry becomes the bit-8 carry out, and zero becomes 1 when the 8-bit result is 0.
- R9: Opcode 3 (subtract) writes register − source to the register. Carry becomes 1 when no borrow occurs (register ≥ source), and zero becomes 1 when the 8-bit result is 0.
- R10: Opcode 1 (move) writes the source to the register. Opcode 4 loads W from `immData`, and opcode 5 loads W from the register. None of these three changes carry or zero.
- R11: Only opcodes 1, 2 and 3 assert `rfWrEn`. Opcodes 0, 4, 5, 6 and 7 leave the register file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction is presented this cycle |
| opCode | input | 3 | Operation code (0 no-op, 1 move, 2 add, 3 sub, 4 load W immediate, 5 load W from register, 6 prefix immediate, 7 prefix register) |
| regAddr | input | AW | Register-file location addressed by the instruction |
| immData | input | DW | Immediate byte |
| rfAddr | output | AW | Register-file read/write address |
| rfRdData | input | DW | Register-file read data, same cycle |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrData | output | DW | Register-file write data |
| wOut | output | DW | Current W value |
| carryOut | output | 1 | Carry flag |
| zeroOut | output | 1 | Zero flag |
| irqHold | output | 1 | Interrupt inhibit, high while a prefix is pending |

## Verification
The bound checker watches the pending-flag protocol on every cycle:
- `irqHold` rises after each prefix and drops after any other valid instruction.
- `irqHold` holds steady across idle cycles.
- W stays stable across a prefix and its consumer.
- The flags stay stable on operations other than add and subtract.
- `rfWrEn` stays low on the operations that must not write.

The arithmetic values cannot be seen by those properties, and only the bench's scenarios show them. These are the sums and differences with their carry and zero results over a swept grid of operands, the latch reload on back-to-back prefixes, and a no-op consuming a pending prefix.

// File: rtl/altop_pkg.sv
package altop_pkg;

  // Instruction encodings seen on opCode
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MOVWF = 3'd1,
    OP_ADDWF = 3'd2,
    OP_SUBWF = 3'd3,
    OP_LDWK  = 3'd4,
    OP_MOVFW = 3'd5,
    OP_PFXK  = 3'd6,
    OP_PFXR  = 3'd7
  } op_e;

  // ALU result selection
  typedef enum logic [1:0] {
    ALU_PASSA = 2'd0,   // register-file operand
    ALU_PASSB = 2'd1,   // source operand (W, latch or immediate)
    ALU_ADD   = 2'd2,
    ALU_SUB   = 2'd3
  } alu_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic useAlt;    // latch replaces W as source
    logic immSrc;    // immediate drives the source operand
    alu_e aluSel;
    logic wrReg;
    logic wrW;
    logic wrLatch;
    logic wrFlags;
  } ctl_t;

endpackage

// File: rtl/altop_ctrl.sv
module altop_ctrl
  import altop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [2:0] opCode,
  output ctl_t       ctl,
  output logic       pending
);

  op_e  op;
  logic isPrefix;

  assign op       = op_e'(opCode);
  assign isPrefix = (op == OP_PFXK) || (op == OP_PFXR);

  always_comb begin
    ctl        = '0;
    ctl.useAlt = pending;
    ctl.aluSel = ALU_PASSB;
    if (instValid) begin
      unique case (op)
        OP_NOP: ;
        OP_MOVWF: begin
          ctl.aluSel = ALU_PASSB;
          ctl.wrReg  = 1'b1;
        end
        OP_ADDWF: begin
          ctl.aluSel  = ALU_ADD;
          ctl.wrReg   = 1'b1;
          ctl.wrFlags = 1'b1;
        end
        OP_SUBWF: begin
          ctl.aluSel  = ALU_SUB;
          ctl.wrReg   = 1'b1;
          ctl.wrFlags = 1'b1;
        end
        OP_LDWK: begin
          ctl.immSrc = 1'b1;
          ctl.aluSel = ALU_PASSB;
          ctl.wrW    = 1'b1;
        end
        OP_MOVFW: begin
          ctl.aluSel = ALU_PASSA;
          ctl.wrW    = 1'b1;
        end
        OP_PFXK: begin
          ctl.immSrc  = 1'b1;
          ctl.aluSel  = ALU_PASSB;
          ctl.wrLatch = 1'b1;
        end
        OP_PFXR: begin
          ctl.aluSel  = ALU_PASSA;
          ctl.wrLatch = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // One-shot substitute flag: any valid non-prefix instruction consumes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pending <= 1'b0;
    else if (instValid) pending <= isPrefix;
  end

endmodule

// File: rtl/altop_dpath.sv
module altop_dpath
  import altop_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] immData,
  input  logic [DW-1:0] rfRdData,
  output logic [AW-1:0] rfAddr,
  output logic          rfWrEn,
  output logic [DW-1:0] rfWrData,
  output logic [DW-1:0] wOut,
  output logic          carryOut,
  output logic          zeroOut
);

  localparam int EW = DW + 1;

  logic [DW-1:0] wReg, altReg, opA, opB, aluRes;
  logic [EW-1:0] extRes;
  logic          aluCarry, carryReg, zeroReg;

  assign opA = rfRdData;
  assign opB = ctl.immSrc ? immData : (ctl.useAlt ? altReg : wReg);

  always_comb begin
    extRes   = '0;
    aluRes   = opB;
    aluCarry = 1'b0;
    unique case (ctl.aluSel)
      ALU_PASSA: aluRes = opA;
      ALU_PASSB: aluRes = opB;
      ALU_ADD: begin
        extRes   = {1'b0, opA} + {1'b0, opB};
        aluRes   = extRes[DW-1:0];
        aluCarry = extRes[DW];
      end
      ALU_SUB: begin
        extRes   = {1'b0, opA} - {1'b0, opB};
        aluRes   = extRes[DW-1:0];
        aluCarry = ~extRes[DW];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wReg     <= '0;
      altReg   <= '0;
      carryReg <= 1'b0;
      zeroReg  <= 1'b0;
    end else begin
      if (ctl.wrW)     wReg   <= aluRes;
      if (ctl.wrLatch) altReg <= aluRes;
      if (ctl.wrFlags) begin
        carryReg <= aluCarry;
        zeroReg  <= (aluRes == '0);
      end
    end
  end

  assign rfAddr   = regAddr;
  assign rfWrEn   = ctl.wrReg;
  assign rfWrData = aluRes;
  assign wOut     = wReg;
  assign carryOut = carryReg;
  assign zeroOut  = zeroReg;

endmodule

// File: rtl/altop_unit.sv
module altop_unit
  import altop_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [2:0]    opCode,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] immData,
  output logic [AW-1:0] rfAddr,
  input  logic [DW-1:0] rfRdData,
  output logic          rfWrEn,
  output logic [DW-1:0] rfWrData,
  output logic [DW-1:0] wOut,
  output logic          carryOut,
  output logic          zeroOut,
  output logic          irqHold
);

  ctl_t ctl;
  logic pending;

  altop_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .opCode    (opCode),
    .ctl       (ctl),
    .pending   (pending)
  );

  altop_dpath #(.DW(DW), .AW(AW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .regAddr  (regAddr),
    .immData  (immData),
    .rfRdData (rfRdData),
    .rfAddr   (rfAddr),
    .rfWrEn   (rfWrEn),
    .rfWrData (rfWrData),
    .wOut     (wOut),
    .carryOut (carryOut),
    .zeroOut  (zeroOut)
  );

  assign irqHold = pending;

endmodule

// File: rtl/altop_chk.sv
module altop_chk
  import altop_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          instValid,
  input logic [2:0]    opCode,
  input logic          rfWrEn,
  input logic [DW-1:0] wOut,
  input logic          carryOut,
  input logic          zeroOut,
  input logic          irqHold
);

  logic isPfx, isArith, isWrOp;
  assign isPfx   = (opCode == OP_PFXK) || (opCode == OP_PFXR);
  assign isArith = (opCode == OP_ADDWF) || (opCode == OP_SUBWF);
  assign isWrOp  = isArith || (opCode == OP_MOVWF);

  AST_HOLD_AFTER_PFX: assert property (@(posedge clk) disable iff (!rstN)
    instValid && isPfx |=> irqHold);                                   // R6

  AST_HOLD_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !isPfx |=> !irqHold);                                 // R4

  AST_IDLE_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> $stable(irqHold) && $stable(wOut));                 // R6

  AST_W_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    instValid && (isPfx || (irqHold && isWrOp)) |=> $stable(wOut));    // R5

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !isArith |=> $stable({carryOut, zeroOut}));           // R10

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && isWrOp) |-> !rfWrEn);                               // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> !irqHold && (wOut == '0) && !carryOut && !zeroOut);      // R1

endmodule

bind altop_unit altop_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .opCode    (opCode),
  .rfWrEn    (rfWrEn),
  .wOut      (wOut),
  .carryOut  (carryOut),
  .zeroOut   (zeroOut),
  .irqHold   (irqHold)
);

// File: tb/altop_unit_tb.sv
`timescale 1ns/1ps
module altop_unit_tb;
  import altop_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] immData = 8'd0;
  logic [3:0] rfAddr;
  logic [7:0] rfRdData;
  logic       rfWrEn;
  logic [7:0] rfWrData;
  logic [7:0] wOut;
  logic       carryOut, zeroOut, irqHold;

  logic [7:0] rf [16];
  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  // bench-side model state, from the requirements
  logic [7:0] mW = 0, mL = 0;
  logic       mP = 0, mC = 0, mZ = 0;

  always #2.5 clk = ~clk;

  assign rfRdData = rf[rfAddr];
  always @(posedge clk) if (rfWrEn) rf[rfAddr] <= rfWrData;

  altop_unit u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opCode(opCode),
    .regAddr(regAddr), .immData(immData), .rfAddr(rfAddr),
    .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrData(rfWrData),
    .wOut(wOut), .carryOut(carryOut), .zeroOut(zeroOut), .irqHold(irqHold)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic exec(input op_e op, input int addr, input int imm, input string req);
    logic [7:0] a, src, expReg;
    logic [8:0] t;
    @(negedge clk);
    instValid = 1'b1; opCode = op; regAddr = addr[3:0]; immData = imm[7:0];
    a = rf[addr]; src = mP ? mL : mW; expReg = a;
    case (op)
      OP_MOVWF: expReg = src;
      OP_ADDWF: begin t = {1'b0, a} + {1'b0, src}; expReg = t[7:0];
                      mC = t[8]; mZ = (t[7:0] == 0); end
      OP_SUBWF: begin expReg = a - src; mC = (a >= src); mZ = (expReg == 0); end
      OP_LDWK:  mW = imm[7:0];
      OP_MOVFW: mW = a;
      OP_PFXK:  mL = imm[7:0];
      OP_PFXR:  mL = a;
      default: ;
    endcase
    mP = (op == OP_PFXK) || (op == OP_PFXR);
    @(posedge clk); #1;
    chk(req, "reg", rf[addr], expReg);
    chk(req, "W", wOut, mW);
    chk(req, "carry", carryOut, mC);
    chk(req, "zero", zeroOut, mZ);
    chk(req, "irqHold", irqHold, mP);
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); instValid = 1'b0;
      @(posedge clk); #1;
      chk(req, "irqHold idle", irqHold, mP);
      chk(req, "W idle", wOut, mW);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 8'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1: state during reset
    chk("R1", "W rst", wOut, 0);
    chk("R1", "hold rst", irqHold, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "W", wOut, 0);
    chk("R1", "carry", carryOut, 0);
    chk("R1", "zero", zeroOut, 0);
    chk("R1", "irqHold", irqHold, 0);

    // Sweep: latch-based copy/add/sub versus plain W path (R2 R3 R5 R8 R9)
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        int va, vb;
        va = ia * 17; vb = ib * 16 + 3;
        exec(OP_LDWK, 0, va ^ vb, "R10");
        exec(OP_PFXK, 0, va, "R2");
        exec(OP_MOVWF, 1, 0, "R2");
        exec(OP_PFXK, 0, vb, "R5");
        exec(OP_MOVWF, 2, 0, "R5");
        exec(OP_PFXR, 2, 0, "R3");
        exec(OP_ADDWF, 1, 0, "R8");
        exec(OP_PFXR, 2, 0, "R3");
        exec(OP_SUBWF, 1, 0, "R9");
        exec(OP_ADDWF, 3, 0, "R4");
        exec(OP_SUBWF, 2, 0, "R9");
      end
    end

    // R10: move and W loads leave flags alone
    exec(OP_LDWK, 0, 8'h5A, "R10");
    exec(OP_MOVWF, 4, 0, "R10");
    exec(OP_MOVFW, 2, 0, "R10");
    // R7: back-to-back prefixes, second wins
    exec(OP_PFXK, 0, 8'h11, "R7");
    exec(OP_PFXK, 0, 8'h22, "R7");
    exec(OP_MOVWF, 5, 0, "R7");
    // R6: idle cycles keep the prefix pending
    exec(OP_PFXK, 0, 8'h33, "R6");
    idle(4, "R6");
    exec(OP_ADDWF, 5, 0, "R6");
    // R4: a no-op consumes the prefix
    exec(OP_PFXK, 0, 8'h44, "R4");
    exec(OP_NOP, 0, 0, "R4");
    exec(OP_MOVWF, 6, 0, "R4");
    // R11: non-writing ops, including under a pending prefix
    exec(OP_PFXR, 5, 0, "R11");
    exec(OP_LDWK, 7, 9, "R11");
    exec(OP_MOVFW, 6, 0, "R11");
    exec(OP_NOP, 6, 0, "R11");
    idle(2, "R11");

    done = 1;
    summary();
  end

endmodule